// File: doc/BRIEF.md
# One-Time-Programmable Lock Sequencer

This block walks a peripheral through its permanent lock procedure over a plain register bus, with no software driving each step. A single-cycle pulse on `start` launches the run. The block first stores the all-ones byte into the lock-byte register. It then sets the engine-enable bit with a read-modify-write and issues the lock command with a second read-modify-write. It polls until the command bit clears itself and reads the status register. The run succeeds when both status flags are set.

If either flag is missing, the block issues the lock command again. It gives up after a fixed number of command attempts and raises `fail`, which marks the part as defective. A command bit that never clears within a programmable number of poll reads also ends the run in `fail`. Each bus transaction holds its request until the peripheral answers with `busReady`.

Top module: `otp_lock_seq`

## Requirements
- R1: After reset `busy`, `done`, `fail`, `busWe` and `busRe` are all 0.
- R2: The first bus transaction after an accepted start is a write of 0xFF to address 0xFA.
- R3: The block then reads address 0x4C and writes back the value it read with bit 0 set, so all other bits keep their values. This write happens before any lock command.
- R4: Each lock command reads address 0x4F and writes back the value it read with bit 2 set, so all other bits keep their values.
- R5: After each lock command the block reads 0x4F again and again until bit 2 reads 0. It then reads address 0x50.
- R6: In the 0x50 value, bit 2 is the lock-good flag and bit 3 is the check-good flag. When both are 1 the run ends with `done`=1.
- R7: When either flag is 0, the block issues the lock command again. After MAX_ATTEMPTS commands (default 10) that all fail this test, the run ends with `fail`=1 and no further command is issued.
- R8: If POLL_LIMIT consecutive poll reads (default 16) all return bit 2 set, the run ends with `fail`=1.
- R9: A request (`busWe` or `busRe` with `busAddr` and `busWdata`) stays unchanged until a cycle with `busReady`=1 completes it. `busWe` and `busRe` are never high together.
- R10: `busy` rises in the cycle after an accepted start and stays high until the cycle in which `done` or `fail` is set. A start while busy is ignored.
- R11: `done` and `fail` are never both 1. Each holds its value while idle until the next start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle launch pulse |
| busAddr | output | ADDR_W | Register address of the current request |
| busWdata | output | DATA_W | Write data of the current request |
| busWe | output | 1 | Write request |
| busRe | output | 1 | Read request |
| busRdata | input | DATA_W | Read data, valid with busReady on a read |
| busReady | input | 1 | Completes the pending request this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run ended with both status flags set |
| fail | output | 1 | Last run exhausted its attempts or timed out polling |

## Verification
A behavioural peripheral model is driven with patterns that differ in four ways: the attempt on which success first comes, how many poll reads the command bit stays set, how many wait cycles come before `busReady`, and which single flag is present on a failing attempt. Success on the first attempt and success on the last allowed attempt separate an off-by-one error in the attempt counter. One missing flag in either position, or both missing, shows that both flags are required. A run that never succeeds separates `fail` from a hang. A command bit that never clears exercises the poll timeout. Non-zero wait cycles show that requests hold steady, and fixed neighbouring bits in 0x4C and 0x4F show that the read-modify-write leaves them intact.

// File: rtl/otp_lock_pkg.sv
package otp_lock_pkg;

  // Register map and bit positions the peripheral decodes
  localparam logic [7:0] AddrLockByte = 8'hFA;
  localparam logic [7:0] AddrConfig   = 8'h4C;
  localparam logic [7:0] AddrControl  = 8'h4F;
  localparam logic [7:0] AddrStatus   = 8'h50;
  localparam logic [7:0] LockByteVal  = 8'hFF;
  localparam int EnableBit  = 0;
  localparam int CommandBit = 2;
  localparam int LockGoodBit  = 2;
  localparam int CheckGoodBit = 3;

  typedef enum logic [2:0] {
    TX_NONE, TX_LOCKBYTE, TX_CFG_RD, TX_CFG_WR,
    TX_CMD_RD, TX_CMD_WR, TX_POLL_RD, TX_STAT_RD
  } txn_e;

  typedef struct packed {
    txn_e txn;
    logic runStart;
    logic attemptInc;
    logic pollInc;
    logic pollClr;
    logic setDone;
    logic setFail;
  } dpCtrl_t;

endpackage

// File: rtl/otp_lock_ctrl.sv
module otp_lock_ctrl
  import otp_lock_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    txnAck,
  input  logic    cmdBitSet,
  input  logic    statusGood,
  input  logic    lastAttempt,
  input  logic    pollExhausted,
  output dpCtrl_t ctl,
  output logic    busy
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOCKBYTE, S_CFG_RD, S_CFG_WR, S_CMD_RD, S_CMD_WR, S_POLL, S_STAT
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          ctl.runStart = 1'b1;
          stateNext    = S_LOCKBYTE;
        end
      end
      S_LOCKBYTE: begin
        ctl.txn = TX_LOCKBYTE;
        if (txnAck) stateNext = S_CFG_RD;
      end
      S_CFG_RD: begin
        ctl.txn = TX_CFG_RD;
        if (txnAck) stateNext = S_CFG_WR;
      end
      S_CFG_WR: begin
        ctl.txn = TX_CFG_WR;
        if (txnAck) stateNext = S_CMD_RD;
      end
      S_CMD_RD: begin
        ctl.txn = TX_CMD_RD;
        if (txnAck) stateNext = S_CMD_WR;
      end
      S_CMD_WR: begin
        ctl.txn = TX_CMD_WR;
        if (txnAck) begin
          ctl.pollClr = 1'b1;
          stateNext   = S_POLL;
        end
      end
      S_POLL: begin
        ctl.txn = TX_POLL_RD;
        if (txnAck) begin
          if (!cmdBitSet) begin
            stateNext = S_STAT;
          end else if (pollExhausted) begin
            ctl.setFail = 1'b1;
            stateNext   = S_IDLE;
          end else begin
            ctl.pollInc = 1'b1;
          end
        end
      end
      S_STAT: begin
        ctl.txn = TX_STAT_RD;
        if (txnAck) begin
          if (statusGood) begin
            ctl.setDone = 1'b1;
            stateNext   = S_IDLE;
          end else if (lastAttempt) begin
            ctl.setFail = 1'b1;
            stateNext   = S_IDLE;
          end else begin
            ctl.attemptInc = 1'b1;
            stateNext      = S_CMD_RD;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/otp_lock_dp.sv
module otp_lock_dp
  import otp_lock_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int MAX_ATTEMPTS = 10,
  parameter int POLL_LIMIT   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWe,
  output logic              busRe,
  output logic              txnAck,
  output logic              cmdBitSet,
  output logic              statusGood,
  output logic              lastAttempt,
  output logic              pollExhausted,
  output logic              done,
  output logic              fail
);

  localparam int ATTEMPT_W = $clog2(MAX_ATTEMPTS + 1);
  localparam int POLL_W    = $clog2(POLL_LIMIT + 1);

  logic [DATA_W-1:0]    shadow;
  logic [ATTEMPT_W-1:0] attemptCnt;
  logic [POLL_W-1:0]    pollCnt;

  // Request decode from the transaction code
  always_comb begin
    busAddr  = '0;
    busWdata = '0;
    busWe    = 1'b0;
    busRe    = 1'b0;
    unique case (ctl.txn)
      TX_LOCKBYTE: begin
        busAddr  = ADDR_W'(AddrLockByte);
        busWdata = DATA_W'(LockByteVal);
        busWe    = 1'b1;
      end
      TX_CFG_RD: begin
        busAddr = ADDR_W'(AddrConfig);
        busRe   = 1'b1;
      end
      TX_CFG_WR: begin
        busAddr  = ADDR_W'(AddrConfig);
        busWdata = shadow | (DATA_W'(1) << EnableBit);
        busWe    = 1'b1;
      end
      TX_CMD_RD, TX_POLL_RD: begin
        busAddr = ADDR_W'(AddrControl);
        busRe   = 1'b1;
      end
      TX_CMD_WR: begin
        busAddr  = ADDR_W'(AddrControl);
        busWdata = shadow | (DATA_W'(1) << CommandBit);
        busWe    = 1'b1;
      end
      TX_STAT_RD: begin
        busAddr = ADDR_W'(AddrStatus);
        busRe   = 1'b1;
      end
      default: ;
    endcase
  end

  assign txnAck        = (busWe || busRe) && busReady;
  assign cmdBitSet     = busRdata[CommandBit];
  assign statusGood    = busRdata[LockGoodBit] && busRdata[CheckGoodBit];
  assign lastAttempt   = (attemptCnt == ATTEMPT_W'(MAX_ATTEMPTS));
  assign pollExhausted = (pollCnt == POLL_W'(POLL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow     <= '0;
      attemptCnt <= '0;
      pollCnt    <= '0;
      done       <= 1'b0;
      fail       <= 1'b0;
    end else begin
      if (txnAck && (ctl.txn == TX_CFG_RD || ctl.txn == TX_CMD_RD))
        shadow <= busRdata;
      if (ctl.runStart)        attemptCnt <= ATTEMPT_W'(1);
      else if (ctl.attemptInc) attemptCnt <= attemptCnt + 1'b1;
      if (ctl.pollClr)         pollCnt <= '0;
      else if (ctl.pollInc)    pollCnt <= pollCnt + 1'b1;
      if (ctl.runStart) begin
        done <= 1'b0;
        fail <= 1'b0;
      end else begin
        if (ctl.setDone) done <= 1'b1;
        if (ctl.setFail) fail <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/otp_lock_seq.sv
module otp_lock_seq
  import otp_lock_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int MAX_ATTEMPTS = 10,
  parameter int POLL_LIMIT   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWe,
  output logic              busRe,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic              busy,
  output logic              done,
  output logic              fail
);

  dpCtrl_t ctl;
  logic txnAck, cmdBitSet, statusGood, lastAttempt, pollExhausted;

  otp_lock_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .txnAck(txnAck),
    .cmdBitSet(cmdBitSet), .statusGood(statusGood),
    .lastAttempt(lastAttempt), .pollExhausted(pollExhausted),
    .ctl(ctl), .busy(busy)
  );

  otp_lock_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MAX_ATTEMPTS(MAX_ATTEMPTS), .POLL_LIMIT(POLL_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busRdata(busRdata), .busReady(busReady),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRe(busRe),
    .txnAck(txnAck), .cmdBitSet(cmdBitSet), .statusGood(statusGood),
    .lastAttempt(lastAttempt), .pollExhausted(pollExhausted),
    .done(done), .fail(fail)
  );

endmodule

// File: rtl/otp_lock_chk.sv
module otp_lock_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busWe,
  input logic              busRe,
  input logic              busReady,
  input logic              busy,
  input logic              done,
  input logic              fail
);

  // R9
  no_dual_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busRe));

  // R9
  request_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe || busRe) && !busReady |=>
      $stable(busAddr) && $stable(busWe) && $stable(busRe) && $stable(busWdata));

  // R2
  first_lockbyte_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> busWe && busAddr == ADDR_W'(8'hFA) && busWdata == DATA_W'(8'hFF));

  // R10
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && start |=> busy && !done && !fail);

  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done || fail);

  // R11
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail));

  // R11
  outcome_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !start |=> $stable(done) && $stable(fail));

endmodule

bind otp_lock_seq otp_lock_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_otp_lock_seq.sv
`timescale 1ns/1ps
module test_otp_lock_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] busAddr, busWdata, busRdata;
  logic       busWe, busRe, busReady, busy, done, fail;

  always #4 clk = ~clk;

  otp_lock_seq i_otp_lock_seq (
    .clk(clk), .rstN(rstN), .start(start),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRe(busRe),
    .busRdata(busRdata), .busReady(busReady),
    .busy(busy), .done(done), .fail(fail)
  );

  // ---------------- peripheral model ----------------
  logic       slvReset = 1'b0;
  int         succeedOn = 1, cmdLat = 0, readyWait = 0;
  logic [7:0] partialPat = 8'h00;

  logic [7:0] regs [256];
  int         waitCnt, txnCount, cmdCount, pollsSeen, pollsLeft, lockWrites;
  logic [7:0] firstAddr, firstData, lastCmdWrite, cfgAtCmd;
  logic       firstWe;

  assign busReady = (busWe || busRe) && (waitCnt == readyWait);
  assign busRdata = regs[busAddr];

  function automatic logic [7:0] statusFor(int n);
    return (n >= succeedOn) ? 8'h0C : partialPat;
  endfunction

  always @(posedge clk) begin
    if (slvReset) begin
      for (int i = 0; i < 256; i++) regs[i] <= 8'h00;
      regs[8'h4C] <= 8'hA0;
      regs[8'h4F] <= 8'h30;
      waitCnt <= 0; txnCount <= 0; cmdCount <= 0; pollsSeen <= 0;
      pollsLeft <= 0; lockWrites <= 0; firstAddr <= 0; firstData <= 0;
      firstWe <= 0; lastCmdWrite <= 0; cfgAtCmd <= 0;
    end else if ((busWe || busRe) && busReady) begin
      waitCnt  <= 0;
      txnCount <= txnCount + 1;
      if (txnCount == 0) begin
        firstAddr <= busAddr; firstData <= busWdata; firstWe <= busWe;
      end
      if (busWe) begin
        regs[busAddr] <= busWdata;
        if (busAddr == 8'hFA) lockWrites <= lockWrites + 1;
        if (busAddr == 8'h4F && busWdata[2]) begin
          cmdCount     <= cmdCount + 1;
          lastCmdWrite <= busWdata;
          cfgAtCmd     <= regs[8'h4C];
          if (cmdLat == 0) begin
            regs[8'h4F] <= busWdata & 8'hFB;
            regs[8'h50] <= statusFor(cmdCount + 1);
          end else begin
            regs[8'h50] <= 8'h00;
            pollsLeft   <= cmdLat;
          end
        end
      end else if (busAddr == 8'h4F && regs[8'h4F][2]) begin
        pollsSeen <= pollsSeen + 1;
        if (pollsLeft <= 1) begin
          regs[8'h4F] <= regs[8'h4F] & 8'hFB;
          regs[8'h50] <= statusFor(cmdCount);
        end else begin
          pollsLeft <= pollsLeft - 1;
        end
      end
    end else if (busWe || busRe) begin
      waitCnt <= waitCnt + 1;
    end
  end

  // ---------------- checking ----------------
  int checks = 0, fails = 0, cycles = 0;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic setupSlave(input int s, input int l, input int w, input logic [7:0] p);
    @(negedge clk);
    succeedOn = s; cmdLat = l; readyWait = w; partialPat = p;
    slvReset = 1'b1;
    @(negedge clk) slvReset = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    if (busy) check(1'b0, "R10 run never ended", 1, 0);
  endtask

  // Table: succeedOn, cmdLat, readyWait, partialPat, expDone, expCmds, expPolls
  localparam int NROW = 6;
  localparam int vSucc [NROW] = '{1, 3, 10, 11, 4, 1};
  localparam int vLat  [NROW] = '{0, 2, 1, 0, 3, 200};
  localparam int vWait [NROW] = '{0, 1, 2, 0, 3, 0};
  localparam int vPart [NROW] = '{8'h00, 8'h04, 8'h08, 8'h00, 8'h04, 8'h00};
  localparam int vDone [NROW] = '{1, 1, 1, 0, 1, 0};
  localparam int vCmds [NROW] = '{1, 3, 10, 10, 4, 1};
  localparam int vPoll [NROW] = '{0, 6, 10, 0, 12, 16};

  initial begin
    slvReset = 1'b1;
    repeat (3) @(negedge clk);
    slvReset = 1'b0;
    // R1 reset state
    check(!busy && !done && !fail, "R1 status after reset", {busy, done, fail}, 0);
    check(!busWe && !busRe, "R1 bus idle after reset", {busWe, busRe}, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int r = 0; r < NROW; r++) begin
      setupSlave(vSucc[r], vLat[r], vWait[r], 8'(vPart[r]));
      pulseStart();
      check(busy == 1'b1, "R10 busy after start", busy, 1);
      waitIdle();
      check(done == vDone[r][0], "R6 done outcome", done, vDone[r]);
      check(fail == !vDone[r][0], "R7 R8 fail outcome", fail, !vDone[r][0]);
      check(cmdCount == vCmds[r], "R7 lock command count", cmdCount, vCmds[r]);
      check(pollsSeen == vPoll[r], "R5 R8 polls with command bit set", pollsSeen, vPoll[r]);
      check(firstWe && firstAddr == 8'hFA && firstData == 8'hFF,
            "R2 first transaction", {firstWe, firstAddr, firstData}, 24'h1FAFF);
      check(cfgAtCmd == 8'hA1, "R3 config before command", cfgAtCmd, 8'hA1);
      check(lastCmdWrite == 8'h34, "R4 command write value", lastCmdWrite, 8'h34);
      check(lockWrites == 1, "R2 single lock-byte write", lockWrites, 1);
    end

    // R10: start while busy is ignored
    setupSlave(3, 2, 1, 8'h04);
    pulseStart();
    repeat (6) @(negedge clk);
    pulseStart();
    waitIdle();
    check(lockWrites == 1, "R10 start while busy ignored", lockWrites, 1);
    check(cmdCount == 3 && done, "R10 run unaffected", cmdCount, 3);

    // R11: done holds while idle, next start clears it
    repeat (20) @(negedge clk);
    check(done && !fail, "R11 done held while idle", {done, fail}, 2);
    setupSlave(1, 0, 0, 8'h00);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(!done && !fail && busy, "R11 start clears outcome", {busy, done, fail}, 4);
    waitIdle();
    check(done, "R11 second run completes", done, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule